// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block sits beside a small processor core. It gathers eleven interrupt sources and a reset entry, and it presents one request strobe and one vector address to the core. Each source is captured as edge- or level-sensitive. Edge captures are held in a latch. Level inputs are passed through as they are. Pending requests are gated by a mask register and a global enable, and the highest-priority survivor is selected. The core takes the vector with an acknowledge pulse and ends the handler with a return pulse.

On every acknowledge the level of the interrupted context is pushed onto a small stack. The matching return pops it. A control bit chooses between two modes. In nested mode only strictly higher priorities may interrupt a running handler. In sequential mode nothing is presented until the handler returns. Software writes three registers through one write port, selected by a 2-bit code: the mask, the control word, and a write-only force/clear word that sets or drops edge latches.

A three-state machine controls what the core sees:
- **BOOT**, entered at reset, presents the reset vector until the first acknowledge (transition *boot-ack*, to RUN).
- **RUN** presents the arbitrated request. A mask write moves it to HOLD (transition *mask-write*).
- **HOLD** blocks all requests for the cycle that follows a mask write. It returns to RUN on the next cycle (transition *hold-expire*), or stays in HOLD if another mask write arrives.

Top module: `irq_vec_ctrl`

## Requirements
- R1: After reset the block asserts `irq_req` with vector 0x0000 until the first `irq_ack`. No other vector is presented before that acknowledge, and that acknowledge does not push the stack.
- R2: Source index and vector are: 0 power-down 0x002C, 1 programmable external 0x0004, 2 level input A 0x0008, 3 level input B 0x000C, 4 serial-0 transmit 0x0010, 5 serial-0 receive 0x0014, 6 edge input 0x0018, 7 byte-DMA 0x001C, 8 serial-1 transmit or programmable input 0x0020, 9 serial-1 receive or programmable input 0x0024, 10 timer 0x0028. A lower index has higher priority, and the lowest eligible pending index is presented.
- R3: A write with `reg_sel`=0 loads `reg_wdata[10:0]` into the mask. Bit i enables source i. Mask bit 0 is ignored: power-down is never masked. The mask resets to all zeros.
- R4: A write with `reg_sel`=1 loads the control word from `reg_wdata[3:0]`. Bits 1, 2 and 3 make sources 1, 8 and 9 edge-sensitive when set and level-sensitive when clear. Sources 2 and 3 are always level-sensitive. Sources 0, 4, 5, 6, 7 and 10 are always edge-sensitive. An edge source latches on a rising input. A level source is pending only while its input is high. The control word resets to zero.
- R5: When the core acknowledges an edge-sensitive source, that source's latch is cleared.
- R6: In the cycle after any mask write, `irq_req` is low.
- R7: A write with `reg_sel`=2 sets the edge latches named in `reg_wdata[10:0]` and clears those named in `reg_wdata[26:16]`. The write has no effect on level-sensitive sources.
- R8: A pulse on `ints_off` stops all requests, including power-down, whatever the mask holds. A pulse on `ints_on` resumes them; `ints_off` wins if both arrive together. Servicing is enabled after reset.
- R9: Control bit 0 selects nested mode (1) or sequential mode (0). Inside a handler, nested mode presents only sources of strictly higher priority than the running one. Sequential mode presents nothing until the return.
- R10: `irq_ack` while `irq_req` is high pushes the current level onto the stack and raises `stk_depth`. `irq_ret` pops the stack, restores the previous level and lowers `stk_depth`. An acknowledge arriving together with a return takes precedence, and the return is ignored.
- R11: A push onto a full stack sets sticky `stk_ovf`. A pop from an empty stack sets sticky `stk_unf`. In both cases depth and contents are left unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_in | input | 11 | Interrupt source inputs, indexed as in R2 |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 mask, 1 control, 2 force/clear |
| reg_wdata | input | 32 | Register write data |
| ints_on | input | 1 | Global enable command pulse |
| ints_off | input | 1 | Global disable command pulse |
| irq_ack | input | 1 | Core takes the presented vector |
| irq_ret | input | 1 | Core returns from the current handler |
| irq_req | output | 1 | Interrupt request to the core |
| irq_vec | output | 16 | Vector address of the presented request |
| stk_depth | output | $clog2(STK_DEPTH+1) | Number of stacked levels |
| stk_ovf | output | 1 | Sticky stack overflow flag |
| stk_unf | output | 1 | Sticky stack underflow flag |

## Verification
Directed sequences apply single sources, pairs of pending sources, and a source arriving inside a running handler. Together they separate the priority order, the mask gating, and the difference between nested and sequential servicing. Level and edge inputs are held or pulsed briefly, which shows which sources stay pending after their input drops. Force and clear writes, global disable and mask writes are placed next to live requests, so the one-cycle block and the override of the mask by power-down can be told apart. A long phase of sparse random source toggling, register writes, acknowledges and returns is compared cycle by cycle with a bench model. This reaches stack overflow, underflow and mixed mode changes.

// File: rtl/irq_vec_pkg.sv
package irq_vec_pkg;
    localparam int NSRC     = 11;
    localparam int LVL_W    = 4;
    localparam int VEC_W    = 16;
    localparam int CTL_W    = 4;
    localparam int WDATA_W  = 32;
    localparam int CLR_LSB  = 16;
    localparam logic [LVL_W-1:0] LVL_NONE = 4'hF;

    // sources that latch on a rising input regardless of the control word
    localparam logic [NSRC-1:0] FIXED_EDGE = 11'b100_1111_0001;
    localparam int SRC_PROG_X = 1;
    localparam int SRC_PROG_Y = 8;
    localparam int SRC_PROG_Z = 9;

    localparam logic [VEC_W-1:0] RESET_VEC = 16'h0000;
    localparam logic [VEC_W-1:0] PWRDN_VEC = 16'h002C;

    localparam logic [1:0] REG_MASK = 2'd0;
    localparam logic [1:0] REG_CTRL = 2'd1;
    localparam logic [1:0] REG_FRC  = 2'd2;

    typedef enum logic [1:0] {
        ST_BOOT = 2'd0,
        ST_RUN  = 2'd1,
        ST_HOLD = 2'd2
    } ctl_state_e;

    function automatic logic [VEC_W-1:0] vec_of(input logic [LVL_W-1:0] idx);
        if (idx == '0) return PWRDN_VEC;
        return {{(VEC_W-LVL_W-2){1'b0}}, idx, 2'b00};
    endfunction
endpackage

// File: rtl/irq_src_latch.sv
module irq_src_latch #(
    parameter int N = 11
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] src_in,
    input  logic [N-1:0] edge_mode,
    input  logic [N-1:0] ack_clr,
    input  logic [N-1:0] frc_set,
    input  logic [N-1:0] frc_clr,
    output logic [N-1:0] pending
);
    for (genvar g = 0; g < N; g++) begin : g_src
        logic prev_q, lat_q, rise, lat_d;

        assign rise  = src_in[g] & ~prev_q;
        assign lat_d = ((lat_q & ~ack_clr[g] & ~frc_clr[g]) | rise | frc_set[g]) & edge_mode[g];
        assign pending[g] = edge_mode[g] ? lat_q : src_in[g];

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                prev_q <= 1'b0;
                lat_q  <= 1'b0;
            end else begin
                prev_q <= src_in[g];
                lat_q  <= lat_d;
            end
        end

        // R5: an acknowledged latch drops unless a new set arrives in the same cycle
        a_r5_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
            (ack_clr[g] && !rise && !frc_set[g]) |=> !lat_q);
    end
endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick import irq_vec_pkg::*; #(
    parameter int N = NSRC
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N-1:0]     pending,
    input  logic [N-1:0]     mask_eff,
    input  logic             nest,
    input  logic             depth_zero,
    input  logic [LVL_W-1:0] cur_lvl,
    output logic             valid,
    output logic [LVL_W-1:0] sel,
    output logic [VEC_W-1:0] vec
);
    logic [N-1:0] elig;

    for (genvar g = 0; g < N; g++) begin : g_elig
        assign elig[g] = pending[g] & mask_eff[g] &
                         (depth_zero | (nest & (LVL_W'(g) < cur_lvl)));
    end

    always_comb begin
        valid = 1'b0;
        sel   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (elig[i]) begin
                valid = 1'b1;
                sel   = LVL_W'(i);
            end
        end
    end

    assign vec = vec_of(sel);

    // R2: nothing eligible ranks above the chosen source
    a_r2_highest_wins: assert property (@(posedge clk) disable iff (!rst_n)
        valid |-> ((pending & mask_eff & ~({N{1'b1}} << sel)) == '0));
    // R3: a maskable winner always has its mask bit set
    a_r3_mask_respected: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && sel != '0) |-> mask_eff[sel]);
endmodule

// File: rtl/irq_lvl_stack.sv
module irq_lvl_stack #(
    parameter int DEPTH = 12,
    parameter int W     = 4,
    localparam int DW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic          pop,
    input  logic [W-1:0]  din,
    output logic [W-1:0]  top,
    output logic [DW-1:0] depth,
    output logic          empty,
    output logic          ovf,
    output logic          unf
);
    logic [W-1:0]  mem [DEPTH];
    logic [DW-1:0] cnt_q;
    logic          full;

    assign full  = (cnt_q == DW'(DEPTH));
    assign empty = (cnt_q == '0);
    assign top   = empty ? '1 : mem[cnt_q - 1'b1];
    assign depth = cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            ovf   <= 1'b0;
            unf   <= 1'b0;
        end else if (push) begin
            if (full) ovf   <= 1'b1;
            else      cnt_q <= cnt_q + 1'b1;
        end else if (pop) begin
            if (empty) unf   <= 1'b1;
            else       cnt_q <= cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (push && !full) mem[cnt_q] <= din;
    end

    // R10: a push with room grows the stack by one
    a_r10_push_grows: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !full) |=> (cnt_q == $past(cnt_q) + 1'b1));
    // R11: a push onto a full stack keeps depth and raises the flag
    a_r11_full_push_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full) |=> (ovf && cnt_q == $past(cnt_q)));
    // R11: a pop from an empty stack keeps depth and raises the flag
    a_r11_empty_pop_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !push && empty) |=> (unf && cnt_q == '0));
endmodule

// File: rtl/irq_vec_ctrl.sv
module irq_vec_ctrl import irq_vec_pkg::*; #(
    parameter int  STK_DEPTH = 12,
    localparam int DW        = $clog2(STK_DEPTH + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NSRC-1:0]    src_in,
    input  logic               reg_wr,
    input  logic [1:0]         reg_sel,
    input  logic [WDATA_W-1:0] reg_wdata,
    input  logic               ints_on,
    input  logic               ints_off,
    input  logic               irq_ack,
    input  logic               irq_ret,
    output logic               irq_req,
    output logic [VEC_W-1:0]   irq_vec,
    output logic [DW-1:0]      stk_depth,
    output logic               stk_ovf,
    output logic               stk_unf
);
    ctl_state_e        state_q, state_d;
    logic [NSRC-1:0]   mask_q, mask_eff, edge_mode, pending;
    logic [NSRC-1:0]   frc_set, frc_clr, ack_clr;
    logic [CTL_W-1:0]  ctl_q;
    logic              glb_en_q;
    logic [LVL_W-1:0]  cur_lvl_q, pick_sel, stk_top;
    logic [VEC_W-1:0]  pick_vec;
    logic              pick_valid, stk_empty, take, pop, mask_wr, frc_wr;

    assign mask_wr  = reg_wr && (reg_sel == REG_MASK);
    assign frc_wr   = reg_wr && (reg_sel == REG_FRC);
    assign mask_eff = {mask_q[NSRC-1:1], 1'b1};
    assign frc_set  = frc_wr ? reg_wdata[NSRC-1:0] : '0;
    assign frc_clr  = frc_wr ? reg_wdata[CLR_LSB +: NSRC] : '0;

    always_comb begin
        edge_mode = FIXED_EDGE;
        edge_mode[SRC_PROG_X] = ctl_q[1];
        edge_mode[SRC_PROG_Y] = ctl_q[2];
        edge_mode[SRC_PROG_Z] = ctl_q[3];
    end

    assign take    = irq_ack && irq_req && (state_q != ST_BOOT);
    assign pop     = irq_ret && !take;
    assign ack_clr = take ? (NSRC'(1) << pick_sel) : '0;

    irq_src_latch #(.N(NSRC)) u_latch (
        .clk(clk), .rst_n(rst_n), .src_in(src_in), .edge_mode(edge_mode),
        .ack_clr(ack_clr), .frc_set(frc_set), .frc_clr(frc_clr), .pending(pending)
    );

    irq_prio_pick #(.N(NSRC)) u_pick (
        .clk(clk), .rst_n(rst_n), .pending(pending), .mask_eff(mask_eff),
        .nest(ctl_q[0]), .depth_zero(stk_empty), .cur_lvl(cur_lvl_q),
        .valid(pick_valid), .sel(pick_sel), .vec(pick_vec)
    );

    irq_lvl_stack #(.DEPTH(STK_DEPTH), .W(LVL_W)) u_stack (
        .clk(clk), .rst_n(rst_n), .push(take), .pop(pop), .din(cur_lvl_q),
        .top(stk_top), .depth(stk_depth), .empty(stk_empty),
        .ovf(stk_ovf), .unf(stk_unf)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_BOOT;
        else        state_q <= state_d;
    end

    // transitions: boot-ack, mask-write, hold-expire
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_BOOT: if (irq_ack) state_d = ST_RUN;
            ST_RUN:  if (mask_wr) state_d = ST_HOLD;
            ST_HOLD: state_d = mask_wr ? ST_HOLD : ST_RUN;
            default: state_d = ST_BOOT;
        endcase
    end

    // outputs
    always_comb begin
        irq_req = 1'b0;
        irq_vec = pick_vec;
        unique case (state_q)
            ST_BOOT: begin
                irq_req = 1'b1;
                irq_vec = RESET_VEC;
            end
            ST_RUN:  irq_req = glb_en_q && pick_valid;
            ST_HOLD: irq_req = 1'b0;
            default: irq_req = 1'b0;
        endcase
    end

    // software-visible registers and in-service level
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_q    <= '0;
            ctl_q     <= '0;
            glb_en_q  <= 1'b1;
            cur_lvl_q <= LVL_NONE;
        end else begin
            if (mask_wr) mask_q <= reg_wdata[NSRC-1:0];
            if (reg_wr && reg_sel == REG_CTRL) ctl_q <= reg_wdata[CTL_W-1:0];
            if (ints_off)     glb_en_q <= 1'b0;
            else if (ints_on) glb_en_q <= 1'b1;
            if (take)                   cur_lvl_q <= pick_sel;
            else if (pop && !stk_empty) cur_lvl_q <= stk_top;
        end
    end

    // R1: the first acknowledge leaves the boot state
    a_r1_leave_boot: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_BOOT && irq_ack) |=> (state_q == ST_RUN));
    // R6: requests are blocked in the cycle after a mask write
    a_r6_hold_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_wr && state_q != ST_BOOT) |=> !irq_req);
    // R8: global disable silences every source
    a_r8_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!glb_en_q && state_q != ST_BOOT) |-> !irq_req);
    // R9: sequential mode never preempts a running handler
    a_r9_seq_no_preempt: assert property (@(posedge clk) disable iff (!rst_n)
        (!stk_empty && !ctl_q[0] && state_q != ST_BOOT) |-> !irq_req);
    // R9: nested mode only presents strictly higher priority
    a_r9_nest_higher: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req && !stk_empty && state_q != ST_BOOT) |-> (pick_sel < cur_lvl_q));
endmodule

// File: tb/irq_vec_ctrl_tb.sv
`timescale 1ns/100ps
module irq_vec_ctrl_tb;
    localparam int TB_STK = 4;
    localparam int DW     = $clog2(TB_STK + 1);
    localparam logic [10:0] ALW_EDGE = 11'b100_1111_0001;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [10:0] src = '0;
    logic        wr = 1'b0, on = 1'b0, off = 1'b0, ack = 1'b0, ret = 1'b0;
    logic [1:0]  sel = '0;
    logic [31:0] wdata = '0;
    logic        irq_req, stk_ovf, stk_unf;
    logic [15:0] irq_vec;
    logic [DW-1:0] stk_depth;

    int checks = 0;
    int fails  = 0;

    // bench model state
    logic [10:0] m_lat, m_prev, m_mask;
    logic [3:0]  m_ctl;
    logic        m_en, m_boot, m_hold, m_ovf, m_unf;
    int          m_depth;
    int          m_lvl;
    int          m_stk [TB_STK];

    always #2.5 clk = ~clk;

    irq_vec_ctrl #(.STK_DEPTH(TB_STK)) u_dut (
        .clk(clk), .rst_n(rst_n), .src_in(src), .reg_wr(wr), .reg_sel(sel),
        .reg_wdata(wdata), .ints_on(on), .ints_off(off), .irq_ack(ack),
        .irq_ret(ret), .irq_req(irq_req), .irq_vec(irq_vec),
        .stk_depth(stk_depth), .stk_ovf(stk_ovf), .stk_unf(stk_unf)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [10:0] m_edge(input logic [3:0] c);
        logic [10:0] e;
        e = ALW_EDGE;
        e[1] = c[1];
        e[8] = c[2];
        e[9] = c[3];
        return e;
    endfunction

    function automatic logic [15:0] m_vec(input int i);
        return (i == 0) ? 16'h002C : 16'(i * 4);
    endfunction

    function automatic void model_eval(output logic r, output int s, output logic [15:0] v);
        logic [10:0] em, pend, meff;
        em   = m_edge(m_ctl);
        pend = (em & m_lat) | (~em & src);
        meff = {m_mask[10:1], 1'b1};
        s = -1;
        for (int i = 10; i >= 0; i--)
            if (pend[i] && meff[i] && (m_depth == 0 || (m_ctl[0] && i < m_lvl))) s = i;
        if (m_boot) begin
            r = 1'b1;
            v = 16'h0000;
        end else begin
            r = !m_hold && m_en && (s >= 0);
            v = (s >= 0) ? m_vec(s) : 16'h0;
        end
    endfunction

    task automatic model_reset();
        m_lat = '0; m_prev = '0; m_mask = '0; m_ctl = '0;
        m_en = 1'b1; m_boot = 1'b1; m_hold = 1'b0; m_ovf = 1'b0; m_unf = 1'b0;
        m_depth = 0; m_lvl = 15;
    endtask

    // one clock: compare with model, advance model, clear pulse inputs
    task automatic tick();
        logic r, take, old_boot;
        int s;
        logic [15:0] v;
        logic [10:0] nl;
        #1;
        model_eval(r, s, v);
        chk("R2 model req", 32'(irq_req), 32'(r));
        if (r) chk("R2 model vec", 32'(irq_vec), 32'(v));
        chk("R10 model depth", 32'(stk_depth), 32'(m_depth));
        chk("R11 model ovf", 32'(stk_ovf), 32'(m_ovf));
        chk("R11 model unf", 32'(stk_unf), 32'(m_unf));
        old_boot = m_boot;
        take = ack && r && !m_boot;
        if (m_boot && ack) m_boot = 1'b0;
        nl = m_lat;
        if (take) nl[s] = 1'b0;
        if (wr && sel == 2'd2) nl = (nl & ~wdata[26:16]) | wdata[10:0];
        m_lat = (nl | (src & ~m_prev)) & m_edge(m_ctl);
        if (take) begin
            if (m_depth == TB_STK) m_ovf = 1'b1;
            else begin
                m_stk[m_depth] = m_lvl;
                m_depth++;
            end
            m_lvl = s;
        end else if (ret) begin
            if (m_depth == 0) m_unf = 1'b1;
            else begin
                m_depth--;
                m_lvl = m_stk[m_depth];
            end
        end
        m_hold = !old_boot && wr && sel == 2'd0;
        if (off) m_en = 1'b0;
        else if (on) m_en = 1'b1;
        if (wr && sel == 2'd0) m_mask = wdata[10:0];
        if (wr && sel == 2'd1) m_ctl = wdata[3:0];
        m_prev = src;
        @(posedge clk);
        @(negedge clk);
        wr = 1'b0; on = 1'b0; off = 1'b0; ack = 1'b0; ret = 1'b0;
    endtask

    task automatic pulse(input int b);
        src[b] = 1'b1;
        tick();
        src[b] = 1'b0;
    endtask

    task automatic wreg(input logic [1:0] s, input logic [31:0] d);
        wr = 1'b1; sel = s; wdata = d;
        tick();
    endtask

    task automatic do_ack();
        ack = 1'b1;
        tick();
    endtask

    task automatic do_ret();
        ret = 1'b1;
        tick();
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        int unsigned seed_v;
        logic r;
        int s;
        logic [15:0] v;
        seed_v = $urandom(32'd2024);
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("R1 reset req", 32'(irq_req), 32'd1);
        chk("R1 reset vec", 32'(irq_vec), 32'h0);
        chk("R11 reset flags", {30'd0, stk_ovf, stk_unf}, 32'd0);

        pulse(10);
        chk("R1 boot keeps reset vec", 32'(irq_vec), 32'h0);
        do_ack();
        chk("R3 timer masked after reset", 32'(irq_req), 32'd0);
        chk("R1 boot ack no push", 32'(stk_depth), 32'd0);
        wreg(2'd0, 32'h7FF);
        chk("R6 blocked after mask write", 32'(irq_req), 32'd0);
        tick();
        chk("R3 timer unmasked vec", 32'(irq_vec), 32'h0028);

        src[4] = 1'b1; src[6] = 1'b1;
        tick();
        src[4] = 1'b0; src[6] = 1'b0;
        chk("R2 serial0 tx beats edge input and timer", 32'(irq_vec), 32'h0010);
        do_ack();
        chk("R9 sequential no preempt", 32'(irq_req), 32'd0);
        chk("R10 depth after ack", 32'(stk_depth), 32'd1);
        do_ret();
        chk("R10 depth after return", 32'(stk_depth), 32'd0);
        chk("R2 edge input next", 32'(irq_vec), 32'h0018);

        wreg(2'd1, 32'h1);
        chk("R4 control write no block", 32'(irq_vec), 32'h0018);
        do_ack();
        chk("R9 nested lower blocked", 32'(irq_req), 32'd0);
        pulse(0);
        chk("R9 nested higher preempts", 32'(irq_vec), 32'h002C);
        do_ack();
        chk("R10 nested depth", 32'(stk_depth), 32'd2);
        do_ret();
        do_ret();
        chk("R10 unwound timer", 32'(irq_vec), 32'h0028);

        off = 1'b1;
        tick();
        chk("R8 disabled timer", 32'(irq_req), 32'd0);
        pulse(0);
        chk("R8 disabled power-down", 32'(irq_req), 32'd0);
        on = 1'b1;
        tick();
        chk("R8 re-enabled power-down", 32'(irq_vec), 32'h002C);
        do_ack();
        do_ret();

        wreg(2'd0, 32'h0);
        tick();
        pulse(0);
        chk("R3 power-down ignores mask", 32'(irq_vec), 32'h002C);
        do_ack();
        do_ret();
        chk("R3 all masked", 32'(irq_req), 32'd0);
        wreg(2'd0, 32'h7FF);
        tick();
        chk("R3 timer back", 32'(irq_vec), 32'h0028);

        src[2] = 1'b1;
        tick();
        chk("R4 level input pending", 32'(irq_vec), 32'h0008);
        src[2] = 1'b0;
        tick();
        chk("R4 level input not latched", 32'(irq_vec), 32'h0028);
        do_ack();
        do_ret();
        chk("R5 timer cleared by ack", 32'(irq_req), 32'd0);

        wreg(2'd1, 32'h3);
        pulse(1);
        chk("R4 programmable edge latched", 32'(irq_vec), 32'h0004);
        do_ack();
        do_ret();
        chk("R5 programmable edge cleared", 32'(irq_req), 32'd0);

        wreg(2'd2, 32'h1 << 7);
        chk("R7 force sets latch", 32'(irq_vec), 32'h001C);
        wreg(2'd2, 32'h1 << 23);
        chk("R7 clear drops latch", 32'(irq_req), 32'd0);
        wreg(2'd2, 32'h1 << 2);
        chk("R7 force ignored on level source", 32'(irq_req), 32'd0);

        do_ret();
        chk("R11 underflow flag", 32'(stk_unf), 32'd1);
        chk("R11 underflow depth", 32'(stk_depth), 32'd0);

        wreg(2'd2, 32'h1 << 10); do_ack();
        wreg(2'd2, 32'h1 << 7);  do_ack();
        wreg(2'd2, 32'h1 << 6);  do_ack();
        wreg(2'd2, 32'h1 << 5);  do_ack();
        chk("R10 full depth", 32'(stk_depth), 32'(TB_STK));
        chk("R11 no overflow yet", 32'(stk_ovf), 32'd0);
        wreg(2'd2, 32'h1 << 4);  do_ack();
        chk("R11 overflow flag", 32'(stk_ovf), 32'd1);
        chk("R11 overflow depth kept", 32'(stk_depth), 32'(TB_STK));
        repeat (4) do_ret();
        chk("R10 unwound to empty", 32'(stk_depth), 32'd0);

        for (int n = 0; n < 3000; n++) begin
            for (int b = 0; b < 11; b++)
                if (($urandom % 16) == 0) src[b] = ~src[b];
            if (($urandom % 20) == 0) begin
                wr = 1'b1;
                sel = 2'($urandom % 3);
                wdata = (sel == 2'd2) ? ($urandom & $urandom & $urandom) : ($urandom | $urandom);
            end
            if (($urandom % 64) == 0) off = 1'b1;
            if (($urandom % 16) == 0) on = 1'b1;
            model_eval(r, s, v);
            if (r && ($urandom % 5) < 2) ack = 1'b1;
            else if (m_depth > 0 && ($urandom % 8) == 0) ret = 1'b1;
            else if (($urandom % 200) == 0) ret = 1'b1;
            tick();
        end

        summary();
        $finish;
    end
endmodule